// File: doc/BRIEF.md
# MSI Vector Interrupt Aggregator

This block collects message-signalled interrupts and presents them to a host as eight grouped, level-style interrupt lines. Each inbound MSI write arrives already decoded as an address and a data word. When the address selects the MSI doorbell, the data word is taken as a vector number, and that number sets one pending bit. The 32 vectors are interleaved across eight groups. The group is the vector modulo 8, and the bit inside the group is the vector divided by 8.

Software works through a plain 32-bit register bus. Each group has three registers: a write-one-to-clear pending register, a write-one-to-set enable register and a write-one-to-clear enable register. A shared end-of-interrupt register acknowledges one group at a time. After an acknowledge, that group's line drops for exactly one cycle. An edge-triggered host controller therefore sees a fresh edge if work is still pending.

Top module: `msi_irq_aggregator`

## Requirements
- R1: An inbound write with `msi_valid` high and `msi_addr` equal to 0x054 takes `msi_data` as vector v and sets pending bit (v >> 3) of group (v mod 8). An inbound write to any other address changes nothing.
- R2: A vector number of 32 or more sets no pending bit in any group.
- R3: The pending register of group n is at 0x104 + 16*n, and bits 3:0 hold the raw pending bits, unmasked. Writing 1 to a bit clears it, and writing 0 to a bit leaves it unchanged.
- R4: Group n's enable-set register is at 0x108 + 16*n and its enable-clear register is at 0x10C + 16*n. In both, a 1 bit sets or clears that enable, and a 0 bit has no effect. A read of either register returns the group's enable mask in bits 3:0.
- R5: `irq_out[n]` is high exactly when some bit of group n is both pending and enabled, with the end-of-interrupt exception of R6. It follows the register state in the cycle after the clock edge that changed it.
- R6: A bus write of value n + 4 to offset 0x050 forces `irq_out[n]` low for the one cycle after that edge. The line then returns to the R5 level. A value below 4 or above 11 has no effect on any line.
- R7: If an MSI event and a write-one-to-clear reach the same pending bit on the same edge, the bit stays set.
- R8: Reset clears all pending and enable bits and drives every line low. A read of any offset not listed in R3 or R4 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msi_valid | input | 1 | Inbound MSI write strobe |
| msi_addr | input | 12 | Decoded inbound write offset |
| msi_data | input | 32 | Inbound write data, the vector number |
| reg_we | input | 1 | Register bus write strobe |
| reg_addr | input | 12 | Register bus offset for reads and writes |
| reg_wdata | input | 32 | Register bus write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| irq_out | output | 8 | One interrupt line per group |

## Verification
The assertions assume a single register bus access per cycle. They also assume that every input is at a known level after reset. The inbound port and the register bus may still act on the same edge, and the collision property depends on that being allowed.

The bench drives all inputs on the falling edge and holds each strobe for one full cycle. It steps the MSI, clear, enable and end-of-interrupt operations in a fixed order, so every edge has a single expected outcome. It raises an MSI and a clear together only in the collision scenario.

// File: rtl/msi_agg_pkg.sv
package msi_agg_pkg;
    // Register kinds found by the bus decoder
    typedef enum logic [2:0] {
        RK_NONE,
        RK_STATUS,
        RK_EN_SET,
        RK_EN_CLR,
        RK_EOI
    } reg_kind_e;

    localparam int MSI_DOORBELL_OFF = 'h054;
    localparam int EOI_OFF          = 'h050;
    localparam int GRP_BASE_OFF     = 'h100;
    localparam int GRP_STRIDE       = 16;
    localparam int SUB_STATUS       = 'h4;
    localparam int SUB_EN_SET       = 'h8;
    localparam int SUB_EN_CLR       = 'hC;
    localparam int EOI_CODE_BASE    = 4;
endpackage

// File: rtl/msi_vector_decode.sv
module msi_vector_decode #(
    parameter int NUM_GROUPS = 8,
    parameter int GRP_BITS   = 4,
    parameter int DATA_W     = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           valid_i,
    input  logic [DATA_W-1:0]              vector_i,
    output logic [NUM_GROUPS*GRP_BITS-1:0] set_o
);
    localparam int NUM_VEC = NUM_GROUPS * GRP_BITS;

    // Flat index g*GRP_BITS+b is set by vector b*NUM_GROUPS+g
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        for (genvar b = 0; b < GRP_BITS; b++) begin : g_bit
            assign set_o[g*GRP_BITS+b] =
                valid_i && (vector_i == DATA_W'(b*NUM_GROUPS + g));
        end
    end

    assert_single_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(set_o));

    assert_oob_vector_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && vector_i >= DATA_W'(NUM_VEC)) |-> (set_o == '0));
endmodule

// File: rtl/msi_reg_decode.sv
module msi_reg_decode
    import msi_agg_pkg::*;
#(
    parameter int NUM_GROUPS = 8,
    parameter int ADDR_W     = 12,
    localparam int GW        = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
    input  logic [ADDR_W-1:0] addr_i,
    output reg_kind_e         kind_o,
    output logic [GW-1:0]     grp_o
);
    localparam int REGION_LEN = NUM_GROUPS * GRP_STRIDE;

    logic [ADDR_W-1:0] rel;
    logic              in_region;

    always_comb begin
        rel       = addr_i - ADDR_W'(GRP_BASE_OFF);
        in_region = (addr_i >= ADDR_W'(GRP_BASE_OFF)) &&
                    ({1'b0, rel} < (ADDR_W+1)'(REGION_LEN));
        grp_o     = rel[4 +: GW];
        kind_o    = RK_NONE;
        if (addr_i == ADDR_W'(EOI_OFF)) begin
            kind_o = RK_EOI;
        end else if (in_region) begin
            case (rel[3:0])
                4'(SUB_STATUS): kind_o = RK_STATUS;
                4'(SUB_EN_SET): kind_o = RK_EN_SET;
                4'(SUB_EN_CLR): kind_o = RK_EN_CLR;
                default:        kind_o = RK_NONE;
            endcase
        end
    end
endmodule

// File: rtl/msi_group.sv
module msi_group #(
    parameter int GRP_BITS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [GRP_BITS-1:0] set_i,
    input  logic [GRP_BITS-1:0] clr_i,
    input  logic [GRP_BITS-1:0] en_set_i,
    input  logic [GRP_BITS-1:0] en_clr_i,
    input  logic                eoi_i,
    output logic [GRP_BITS-1:0] pend_o,
    output logic [GRP_BITS-1:0] en_o,
    output logic                irq_o
);
    typedef struct packed {
        logic [GRP_BITS-1:0] pend;
        logic [GRP_BITS-1:0] en;
        logic                blank;
    } grp_state_t;

    grp_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        // A new event outranks a same-edge clear
        st_d.pend  = (st_q.pend & ~clr_i) | set_i;
        st_d.en    = (st_q.en | en_set_i) & ~en_clr_i;
        st_d.blank = eoi_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;
    assign en_o   = st_q.en;
    assign irq_o  = (|(st_q.pend & st_q.en)) && !st_q.blank;

    assert_event_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((pend_o & $past(set_i)) == $past(set_i)));

    assert_clear_drops_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_i & ~set_i) != '0) |=> ((pend_o & $past(clr_i & ~set_i)) == '0));

    assert_en_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en_clr_i != '0) |=> ((en_o & $past(en_clr_i)) == '0));

    assert_line_needs_work_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ((pend_o & en_o) != '0));

    assert_eoi_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_i |=> !irq_o);
endmodule

// File: rtl/msi_irq_aggregator.sv
module msi_irq_aggregator
    import msi_agg_pkg::*;
#(
    parameter int NUM_GROUPS = 8,
    parameter int GRP_BITS   = 4,
    parameter int ADDR_W     = 12,
    parameter int DATA_W     = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  msi_valid,
    input  logic [ADDR_W-1:0]     msi_addr,
    input  logic [DATA_W-1:0]     msi_data,
    input  logic                  reg_we,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    output logic [NUM_GROUPS-1:0] irq_out
);
    localparam int GW     = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1;
    localparam int FLAT_W = NUM_GROUPS * GRP_BITS;

    logic              doorbell;
    logic [FLAT_W-1:0] set_flat;
    logic [FLAT_W-1:0] pend_flat;
    logic [FLAT_W-1:0] en_flat;
    reg_kind_e         kind;
    logic [GW-1:0]     grp_sel;

    assign doorbell = msi_valid && (msi_addr == ADDR_W'(MSI_DOORBELL_OFF));

    msi_vector_decode #(
        .NUM_GROUPS(NUM_GROUPS), .GRP_BITS(GRP_BITS), .DATA_W(DATA_W)
    ) u_vec (
        .clk(clk), .rst_n(rst_n), .valid_i(doorbell),
        .vector_i(msi_data), .set_o(set_flat)
    );

    msi_reg_decode #(
        .NUM_GROUPS(NUM_GROUPS), .ADDR_W(ADDR_W)
    ) u_dec (
        .addr_i(reg_addr), .kind_o(kind), .grp_o(grp_sel)
    );

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        logic                hit;
        logic [GRP_BITS-1:0] clr_v, ens_v, enc_v;
        logic                eoi_v;

        assign hit   = reg_we && (grp_sel == GW'(g));
        assign clr_v = (hit && kind == RK_STATUS) ? reg_wdata[GRP_BITS-1:0] : '0;
        assign ens_v = (hit && kind == RK_EN_SET) ? reg_wdata[GRP_BITS-1:0] : '0;
        assign enc_v = (hit && kind == RK_EN_CLR) ? reg_wdata[GRP_BITS-1:0] : '0;
        assign eoi_v = reg_we && (kind == RK_EOI) &&
                       (reg_wdata == DATA_W'(g + EOI_CODE_BASE));

        msi_group #(.GRP_BITS(GRP_BITS)) u_grp (
            .clk(clk), .rst_n(rst_n),
            .set_i(set_flat[g*GRP_BITS +: GRP_BITS]),
            .clr_i(clr_v), .en_set_i(ens_v), .en_clr_i(enc_v), .eoi_i(eoi_v),
            .pend_o(pend_flat[g*GRP_BITS +: GRP_BITS]),
            .en_o(en_flat[g*GRP_BITS +: GRP_BITS]),
            .irq_o(irq_out[g])
        );
    end

    always_comb begin
        reg_rdata = '0;
        case (kind)
            RK_STATUS: reg_rdata[GRP_BITS-1:0] = pend_flat[grp_sel*GRP_BITS +: GRP_BITS];
            RK_EN_SET,
            RK_EN_CLR: reg_rdata[GRP_BITS-1:0] = en_flat[grp_sel*GRP_BITS +: GRP_BITS];
            default:   reg_rdata = '0;
        endcase
    end

    assert_other_addr_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!doorbell && !reg_we) |=> (pend_flat == $past(pend_flat)));

    assert_unmapped_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == RK_NONE || kind == RK_EOI) |-> (reg_rdata == '0));
endmodule

// File: tb/sim_msi_irq_aggregator.sv
module sim_msi_irq_aggregator;
    localparam int NG = 8;
    localparam int NB = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        msi_valid = 1'b0;
    logic [11:0] msi_addr = '0;
    logic [31:0] msi_data = '0;
    logic        reg_we = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [7:0]  irq_out;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [NB-1:0] m_pend [NG];
    logic [NB-1:0] m_en   [NG];

    always #4 clk = ~clk;

    msi_irq_aggregator u0 (
        .clk(clk), .rst_n(rst_n), .msi_valid(msi_valid), .msi_addr(msi_addr),
        .msi_data(msi_data), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out)
    );

    function automatic logic [11:0] a_stat(int g); return 12'(32'h104 + 16*g); endfunction
    function automatic logic [11:0] a_ens(int g);  return 12'(32'h108 + 16*g); endfunction
    function automatic logic [11:0] a_enc(int g);  return 12'(32'h10C + 16*g); endfunction

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic bus_wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic bus_rd(logic [11:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic msi(logic [11:0] a, logic [31:0] v);
        @(negedge clk);
        msi_valid = 1'b1; msi_addr = a; msi_data = v;
        @(negedge clk);
        msi_valid = 1'b0;
    endtask

    function automatic logic [7:0] exp_irq();
        logic [7:0] r;
        for (int g = 0; g < NG; g++) r[g] = |(m_pend[g] & m_en[g]);
        return r;
    endfunction

    task automatic check_all(string req);
        logic [31:0] d;
        for (int g = 0; g < NG; g++) begin
            bus_rd(a_stat(g), d); chk(req, d, 32'(m_pend[g]));
            bus_rd(a_ens(g), d);  chk(req, d, 32'(m_en[g]));
            bus_rd(a_enc(g), d);  chk(req, d, 32'(m_en[g]));
        end
        chk(req, 32'(irq_out), 32'(exp_irq()));
    endtask

    task automatic t_reset;
        check_all("R8 reset");
    endtask

    task automatic t_unmapped;
        logic [31:0] d;
        bus_rd(12'h000, d); chk("R8 unmapped 000", d, 0);
        bus_rd(12'h054, d); chk("R8 unmapped 054", d, 0);
        bus_rd(12'h050, d); chk("R8 unmapped 050", d, 0);
        bus_rd(12'h100, d); chk("R8 unmapped 100", d, 0);
        bus_rd(12'h180, d); chk("R8 unmapped 180", d, 0);
    endtask

    task automatic t_msi_map;
        int vs [4] = '{0, 9, 31, 18};
        foreach (vs[i]) begin
            msi(12'h054, vs[i]);
            m_pend[vs[i] % 8][vs[i] >> 3] = 1'b1;
        end
        check_all("R1 vector map");
        chk("R5 masked lines low", 32'(irq_out), 0);
    endtask

    task automatic t_ignored;
        msi(12'h054, 32);
        msi(12'h054, 200);
        msi(12'h058, 5);
        msi(12'h000, 6);
        check_all("R2 R1 ignored writes");
    endtask

    task automatic t_enable;
        logic [31:0] d;
        bus_wr(a_ens(1), 32'h2); m_en[1] = 4'h2;
        bus_rd(a_ens(1), d); chk("R4 enable set", d, 32'h2);
        chk("R5 line 1 high", 32'(irq_out), 32'h02);
        bus_wr(a_ens(1), 32'h0);
        bus_rd(a_enc(1), d); chk("R4 zero set no effect", d, 32'h2);
        bus_wr(a_ens(3), 32'hC); m_en[3] = 4'hC;
        bus_wr(a_enc(3), 32'h0);
        check_all("R4 zero clear no effect");
        bus_wr(a_enc(1), 32'h2); m_en[1] = 4'h0;
        chk("R5 line 1 drops", 32'(irq_out), 32'(exp_irq()));
        check_all("R4 enable clear");
        bus_wr(a_ens(1), 32'h2); m_en[1] = 4'h2;
    endtask

    task automatic t_w1c;
        bus_wr(a_stat(1), 32'h0);
        check_all("R3 zero write keeps");
        bus_wr(a_stat(1), 32'h2); m_pend[1] = 4'h0;
        check_all("R3 w1c clears");
        chk("R5 line 1 low after clear", 32'(irq_out[1]), 0);
    endtask

    task automatic t_eoi;
        msi(12'h054, 1); m_pend[1][0] = 1'b1;
        bus_wr(a_ens(1), 32'h1); m_en[1] = 4'h3;
        chk("R5 line 1 high", 32'(irq_out[1]), 1);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 12'h050; reg_wdata = 32'd5;
        @(negedge clk);
        reg_we = 1'b0;
        chk("R6 gap cycle", 32'(irq_out[1]), 0);
        chk("R6 other lines", 32'(irq_out & 8'hFD), 32'(exp_irq() & 8'hFD));
        @(negedge clk);
        chk("R6 reasserts", 32'(irq_out[1]), 1);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 12'h050; reg_wdata = 32'd3;
        @(negedge clk);
        reg_we = 1'b0;
        chk("R6 code 3 no effect", 32'(irq_out), 32'(exp_irq()));
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 12'h050; reg_wdata = 32'd12;
        @(negedge clk);
        reg_we = 1'b0;
        chk("R6 code 12 no effect", 32'(irq_out), 32'(exp_irq()));
    endtask

    task automatic t_collision;
        logic [31:0] d;
        @(negedge clk);
        msi_valid = 1'b1; msi_addr = 12'h054; msi_data = 32'd10;
        reg_we = 1'b1; reg_addr = a_stat(2); reg_wdata = 32'h2;
        @(negedge clk);
        msi_valid = 1'b0; reg_we = 1'b0;
        m_pend[2][1] = 1'b1;
        bus_rd(a_stat(2), d); chk("R7 event wins", d, 32'(m_pend[2]));
        check_all("R7 state");
    endtask

    initial begin
        for (int g = 0; g < NG; g++) begin m_pend[g] = '0; m_en[g] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_unmapped();
        t_msi_map();
        t_ignored();
        t_enable();
        t_w1c();
        t_eoi();
        t_collision();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            done = 1'b1;
            n_run++; n_fail++;
            $display("FAIL watchdog got=hung exp=finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule